// File: doc/BRIEF.md
# Power Mode Clock Controller

This block is the power-mode sequencer of a small microcontroller. Software loads an 8-bit control word that holds the mode request bits, a bit that defers mode changes until a WAIT instruction, and the bits that decide when the high-frequency oscillator and the PLL are gated. From that word, the WAIT strobe, a hardware wake-up event, an oscillator-stable flag, an external PLL power-down level and a radio link controller sleep level, the block chooses one of four modes: Active, Power Save, Idle or Halt. It then drives enables for the system clock, the oscillator and the PLL.

Halt is entered in two steps. The system clock stops first, and the oscillator and PLL stop one cycle later. A wake-up event restarts only the oscillator. The block goes back to Active once that oscillator reports it is stable. Hardware clears some control bits. The gating-disable bits are cleared on any wake-up event, and the radio-dependent gating bits are cleared on every return to Active. The control word can be read back at any time.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: When control bit 3 (defer) is 0 and bit 0 (power-save request) is 1, the block goes from Active to Power Save one cycle after the word is stored. No WAIT is needed.
- R2: When bit 3 is 1, the block stays in Active until a WAIT strobe arrives, whatever request bits are set. The `pwr_mode` encoding is 0 Active, 1 Power Save, 2 Idle, 3 Halt.
- R3: A write that sets bit 2 (halt request) while its own bit 3 is 0 stores bit 2 as 0. A later WAIT then leaves the block in Active.
- R4: On a WAIT with bit 2 set, `sysclk_en` drops while `osc_en` and `pll_en` stay high. On the next cycle all three are low.
- R5: A wake-up event in Halt raises `osc_en` and keeps `sysclk_en` and `pll_en` low. Halt is held until `osc_stable` is seen. On that edge the block enters Active and clears bits 0 to 2.
- R6: `osc_en` is always 1 in Active and always 0 in Halt once the clocks are stopped. In Power Save and Idle it is 0 when bit 4 (oscillator disable) is 1.
- R7: In Power Save and Idle, `pll_en` is 0 when bit 5 (PLL disable) or `pll_pwrdn` is 1. In Active, `pll_en` is the inverse of `pll_pwrdn`. In Halt it is 0.
- R8: Any wake-up event clears bits 4 and 5. The clear wins over a software write in the same cycle.
- R9: With bit 6 (radio-gated oscillator) set, in Power Save or Idle the oscillator is off only while `radio_sleep` is 1. Bit 7 (radio-gated PLL) does the same for the PLL.
- R10: Bits 6 and 7 are cleared on every entry into Active. The clear wins over a same-cycle write.
- R11: Disable bits have no effect in Active. With bit 3 set, the oscillator and PLL stay on until the WAIT has moved the block into a low-power mode.
- R12: When several request bits are pending at a WAIT, Halt wins over Idle and Idle wins over Power Save. A wake-up event in Power Save or Idle returns the block to Active and clears bits 0 and 1.
- R13: After reset the mode is Active, all three enables are 1 and the control word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Control word readback |
| wait_exec | input | 1 | One-cycle strobe for a WAIT instruction |
| wake_evt | input | 1 | Hardware wake-up event |
| osc_stable | input | 1 | Oscillator has stabilized |
| pll_pwrdn | input | 1 | External PLL power-down level |
| radio_sleep | input | 1 | Radio link controller is asleep |
| pwr_mode | output | 2 | Current mode (0 Active, 1 Power Save, 2 Idle, 3 Halt) |
| sysclk_en | output | 1 | System clock enable |
| osc_en | output | 1 | High-frequency oscillator enable |
| pll_en | output | 1 | PLL enable |

## Verification
A software write and a hardware clear can hit the same control bits in the same cycle. This happens when a wake-up event clears bits 4 and 5, or when the return to Active clears bits 6 and 7, while software is writing the word. The bench provokes both cases. In one, it writes ones into bits 4 and 5 on the same edge as a wake-up event. In the other, it writes ones into bits 6 and 7 on the edge where a wake-up moves the block from Idle back to Active. It judges the outcome from the readback on the following half cycle, where the hardware clear must have won and every other written bit must have been kept.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int CTRL_W = 8;
  localparam int MODE_W = 2;

  localparam int B_PSV  = 0;
  localparam int B_IDL  = 1;
  localparam int B_HLT  = 2;
  localparam int B_DEF  = 3;
  localparam int B_OSCD = 4;
  localparam int B_PLLD = 5;
  localparam int B_ROSC = 6;
  localparam int B_RPLL = 7;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_PSAVE  = 3'd1,
    ST_IDLE   = 3'd2,
    ST_HSTOP  = 3'd3,
    ST_HALT   = 3'd4,
    ST_WAKE   = 3'd5
  } pmc_state_e;

  function automatic logic is_low(input pmc_state_e s);
    return (s == ST_PSAVE) || (s == ST_IDLE);
  endfunction

  function automatic logic [MODE_W-1:0] mode_code(input pmc_state_e s);
    case (s)
      ST_ACTIVE: return 2'd0;
      ST_PSAVE:  return 2'd1;
      ST_IDLE:   return 2'd2;
      default:   return 2'd3;
    endcase
  endfunction

  // Halt request only survives a write that also sets the defer bit.
  function automatic logic [CTRL_W-1:0] sanitize(input logic [CTRL_W-1:0] d);
    logic [CTRL_W-1:0] r;
    r = d;
    if (!d[B_DEF]) r[B_HLT] = 1'b0;
    return r;
  endfunction

  // Target state for a WAIT strobe: halt over idle over power save.
  function automatic pmc_state_e wait_target(input logic [CTRL_W-1:0] c);
    if (c[B_HLT])      return ST_HSTOP;
    else if (c[B_IDL]) return ST_IDLE;
    else if (c[B_PSV]) return ST_PSAVE;
    else               return ST_ACTIVE;
  endfunction

  function automatic logic osc_gate(input pmc_state_e s, input logic [CTRL_W-1:0] c,
                                    input logic rsleep);
    case (s)
      ST_PSAVE, ST_IDLE: return !(c[B_OSCD] || (c[B_ROSC] && rsleep));
      ST_HALT:           return 1'b0;
      default:           return 1'b1;
    endcase
  endfunction

  function automatic logic pll_gate(input pmc_state_e s, input logic [CTRL_W-1:0] c,
                                    input logic pdn, input logic rsleep);
    case (s)
      ST_ACTIVE:         return !pdn;
      ST_PSAVE, ST_IDLE: return !(c[B_PLLD] || pdn || (c[B_RPLL] && rsleep));
      ST_HSTOP:          return 1'b1;
      default:           return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              wake_hit,
  input  logic              clr_req,
  input  logic              enter_active,
  output logic [CTRL_W-1:0] ctrl
);
  logic [CTRL_W-1:0] wr_val;
  logic [CTRL_W-1:0] clr_mask;
  logic [CTRL_W-1:0] ctrl_nxt;

  always_comb begin
    wr_val   = we ? sanitize(wdata) : ctrl;
    clr_mask = '0;
    if (wake_hit) begin
      clr_mask[B_OSCD] = 1'b1;
      clr_mask[B_PLLD] = 1'b1;
    end
    if (clr_req) begin
      clr_mask[B_PSV] = 1'b1;
      clr_mask[B_IDL] = 1'b1;
      clr_mask[B_HLT] = 1'b1;
    end
    if (enter_active) begin
      clr_mask[B_ROSC] = 1'b1;
      clr_mask[B_RPLL] = 1'b1;
    end
    ctrl_nxt = wr_val & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else        ctrl <= ctrl_nxt;
  end

  AST_WAKE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> !ctrl[B_OSCD] && !ctrl[B_PLLD]); // R8
  AST_RADIO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    enter_active |=> !ctrl[B_ROSC] && !ctrl[B_RPLL]); // R10
  AST_HALT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl[B_HLT]) |-> ctrl[B_DEF]); // R3
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              wait_exec,
  input  logic              wake_evt,
  input  logic              osc_stable,
  output pmc_state_e        st,
  output logic              clr_req,
  output logic              enter_active
);
  pmc_state_e st_nxt;
  logic       ev_wait_go;
  logic       ev_quick_psv;
  logic       ev_low_wake;
  logic       ev_halt_done;

  assign ev_wait_go   = (st == ST_ACTIVE) && wait_exec && (wait_target(ctrl) != ST_ACTIVE);
  assign ev_quick_psv = (st == ST_ACTIVE) && !ctrl[B_DEF] && ctrl[B_PSV];
  assign ev_low_wake  = is_low(st) && wake_evt;
  assign ev_halt_done = (st == ST_WAKE) && osc_stable;

  always_comb begin
    st_nxt = st;
    case (st)
      ST_ACTIVE: begin
        if (ev_wait_go)        st_nxt = wait_target(ctrl);
        else if (ev_quick_psv) st_nxt = ST_PSAVE;
      end
      ST_PSAVE, ST_IDLE: if (wake_evt) st_nxt = ST_ACTIVE;
      ST_HSTOP: st_nxt = wake_evt ? ST_WAKE : ST_HALT;
      ST_HALT:  if (wake_evt) st_nxt = ST_WAKE;
      ST_WAKE:  if (osc_stable) st_nxt = ST_ACTIVE;
      default:  st_nxt = ST_ACTIVE;
    endcase
  end

  assign clr_req      = ev_low_wake || ev_halt_done;
  assign enter_active = ev_low_wake || ev_halt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_ACTIVE;
    else        st <= st_nxt;
  end

  AST_QUICK_PSV: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE && !ctrl[B_DEF] && ctrl[B_PSV] && !wait_exec) |=> st == ST_PSAVE); // R1
  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE && ctrl[B_DEF] && !wait_exec) |=> st == ST_ACTIVE); // R2
  AST_STOP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HSTOP) |=> (st == ST_HALT || st == ST_WAKE)); // R4
  AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAKE && !osc_stable) |=> st == ST_WAKE); // R5
  AST_HALT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE && wait_exec && ctrl[B_HLT]) |=> st == ST_HSTOP); // R12
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pmc_state_e        st,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              pll_pwrdn,
  input  logic              radio_sleep,
  output logic              sysclk_en,
  output logic              osc_en,
  output logic              pll_en
);
  assign sysclk_en = (st == ST_ACTIVE) || is_low(st);
  assign osc_en    = osc_gate(st, ctrl, radio_sleep);
  assign pll_en    = pll_gate(st, ctrl, pll_pwrdn, radio_sleep);

  AST_ACTIVE_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE) |-> osc_en); // R6
  AST_HALT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALT) |-> !osc_en && !pll_en && !sysclk_en); // R7
  AST_RADIO_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_low(st) && !ctrl[B_OSCD] && !radio_sleep) |-> osc_en); // R9
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  input  logic              wait_exec,
  input  logic              wake_evt,
  input  logic              osc_stable,
  input  logic              pll_pwrdn,
  input  logic              radio_sleep,
  output logic [MODE_W-1:0] pwr_mode,
  output logic              sysclk_en,
  output logic              osc_en,
  output logic              pll_en
);
  logic [CTRL_W-1:0] ctrl;
  pmc_state_e        st;
  logic              clr_req;
  logic              enter_active;

  pmc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .wake_hit(wake_evt), .clr_req(clr_req), .enter_active(enter_active),
    .ctrl(ctrl)
  );

  pmc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .wait_exec(wait_exec),
    .wake_evt(wake_evt), .osc_stable(osc_stable), .st(st),
    .clr_req(clr_req), .enter_active(enter_active)
  );

  pmc_clk_gate u_gate (
    .clk(clk), .rst_n(rst_n), .st(st), .ctrl(ctrl), .pll_pwrdn(pll_pwrdn),
    .radio_sleep(radio_sleep), .sysclk_en(sysclk_en), .osc_en(osc_en),
    .pll_en(pll_en)
  );

  assign cfg_rdata = ctrl;
  assign pwr_mode  = mode_code(st);

  AST_CLK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sysclk_en) |-> osc_en && pll_en); // R4
  AST_DEFER_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd0 && !pll_pwrdn) |-> osc_en && pll_en); // R11
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       wait_exec = 1'b0;
  logic       wake_evt = 1'b0;
  logic       osc_stable = 1'b0;
  logic       pll_pwrdn = 1'b0;
  logic       radio_sleep = 1'b0;
  logic [1:0] pwr_mode;
  logic       sysclk_en, osc_en, pll_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [1:0] mode;
    logic       sc, oc, pl;
    logic [7:0] cw;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wait_exec(wait_exec), .wake_evt(wake_evt),
    .osc_stable(osc_stable), .pll_pwrdn(pll_pwrdn), .radio_sleep(radio_sleep),
    .pwr_mode(pwr_mode), .sysclk_en(sysclk_en), .osc_en(osc_en), .pll_en(pll_en)
  );

  // Monitor: compares pending expectations half a cycle after the edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (pwr_mode !== e.mode || sysclk_en !== e.sc || osc_en !== e.oc ||
          pll_en !== e.pl || cfg_rdata !== e.cw) begin
        n_bad++;
        $display("FAIL %s: got mode=%0d sys=%b osc=%b pll=%b ctrl=%h, exp mode=%0d sys=%b osc=%b pll=%b ctrl=%h",
                 e.tag, pwr_mode, sysclk_en, osc_en, pll_en, cfg_rdata,
                 e.mode, e.sc, e.oc, e.pl, e.cw);
      end
    end
  end

  task automatic expect_out(input string tag, input logic [1:0] m, input logic s,
                            input logic o, input logic p, input logic [7:0] c);
    exp_t e;
    e.tag = tag; e.mode = m; e.sc = s; e.oc = o; e.pl = p; e.cw = c;
    sb_q.push_back(e);
  endtask

  // One active edge with the given strobes, then strobes cleared.
  task automatic step(input bit we, input logic [7:0] d, input bit wt,
                      input bit wk, input bit stb);
    @(posedge clk); #1;
    cfg_we = we; cfg_wdata = d; wait_exec = wt; wake_evt = wk; osc_stable = stb;
    @(posedge clk); #1;
    cfg_we = 1'b0; wait_exec = 1'b0; wake_evt = 1'b0; osc_stable = 1'b0;
  endtask

  task automatic set_levels(input bit rs, input bit pd);
    @(negedge clk); #1;
    radio_sleep = rs; pll_pwrdn = pd;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    expect_out("R13 reset", 2'd0, 1, 1, 1, 8'h00);

    // R1 immediate power save
    step(1, 8'h01, 0, 0, 0);
    expect_out("R1 stored", 2'd0, 1, 1, 1, 8'h01);
    step(0, 8'h00, 0, 0, 0);
    expect_out("R1 psave", 2'd1, 1, 1, 1, 8'h01);
    step(0, 8'h00, 0, 1, 0);
    expect_out("R12 wake psave", 2'd0, 1, 1, 1, 8'h00);

    // R2 / R11 deferral with oscillator disable
    step(1, 8'h19, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0);
    expect_out("R11 deferred osc on", 2'd0, 1, 1, 1, 8'h19);
    step(0, 8'h00, 1, 0, 0);
    expect_out("R6 psave osc off", 2'd1, 1, 0, 1, 8'h19);
    step(0, 8'h00, 0, 1, 0);
    expect_out("R8 wake clears", 2'd0, 1, 1, 1, 8'h08);

    // R12 priority and R4/R5 halt sequence
    step(1, 8'h0F, 0, 0, 0);
    step(0, 8'h00, 1, 0, 0);
    expect_out("R4 sysclk first", 2'd3, 0, 1, 1, 8'h0F);
    step(0, 8'h00, 0, 0, 0);
    expect_out("R4 all off", 2'd3, 0, 0, 0, 8'h0F);
    step(0, 8'h00, 0, 1, 0);
    expect_out("R5 osc restart", 2'd3, 0, 1, 0, 8'h0F);
    step(0, 8'h00, 0, 0, 0);
    expect_out("R5 wait stable", 2'd3, 0, 1, 0, 8'h0F);
    step(0, 8'h00, 0, 0, 1);
    expect_out("R5 stable active", 2'd0, 1, 1, 1, 8'h08);

    // R3 halt without defer ignored
    step(1, 8'h04, 0, 0, 0);
    expect_out("R3 halt dropped", 2'd0, 1, 1, 1, 8'h00);
    step(0, 8'h00, 1, 0, 0);
    expect_out("R3 stays active", 2'd0, 1, 1, 1, 8'h00);

    // R12 idle beats power save
    step(1, 8'h0B, 0, 0, 0);
    step(0, 8'h00, 1, 0, 0);
    expect_out("R12 idle first", 2'd2, 1, 1, 1, 8'h0B);
    step(0, 8'h00, 0, 1, 0);
    expect_out("R12 wake idle", 2'd0, 1, 1, 1, 8'h08);

    // R7 PLL disable bit and external power-down
    step(1, 8'h29, 0, 0, 0);
    step(0, 8'h00, 1, 0, 0);
    expect_out("R7 pll disable", 2'd1, 1, 1, 0, 8'h29);
    step(0, 8'h00, 0, 1, 0);
    step(1, 8'h09, 0, 0, 0);
    set_levels(0, 1);
    expect_out("R7 active pwrdn", 2'd0, 1, 1, 0, 8'h09);
    step(0, 8'h00, 1, 0, 0);
    expect_out("R7 psave pwrdn", 2'd1, 1, 1, 0, 8'h09);
    step(0, 8'h00, 0, 1, 0);
    set_levels(0, 0);
    expect_out("R7 back", 2'd0, 1, 1, 1, 8'h08);

    // R9 radio gating, R10 clear on active
    step(1, 8'hC9, 0, 0, 0);
    step(0, 8'h00, 1, 0, 0);
    expect_out("R9 radio awake", 2'd1, 1, 1, 1, 8'hC9);
    set_levels(1, 0);
    expect_out("R9 radio asleep", 2'd1, 1, 0, 0, 8'hC9);
    step(0, 8'h00, 0, 1, 0);
    expect_out("R10 cleared on active", 2'd0, 1, 1, 1, 8'h08);
    step(1, 8'hC8, 0, 0, 0);
    expect_out("R11 radio gate ignored active", 2'd0, 1, 1, 1, 8'hC8);
    set_levels(0, 0);

    // Collisions: write against hardware clears
    step(1, 8'h38, 0, 1, 0);
    expect_out("R8 clear beats write", 2'd0, 1, 1, 1, 8'h08);
    step(1, 8'h0A, 0, 0, 0);
    step(0, 8'h00, 1, 0, 0);
    expect_out("R2 idle via wait", 2'd2, 1, 1, 1, 8'h0A);
    step(1, 8'hCA, 0, 1, 0);
    expect_out("R10 clear beats write", 2'd0, 1, 1, 1, 8'h08);

    // R2 empty wait, R8 wake in active
    step(0, 8'h00, 1, 0, 0);
    expect_out("R2 empty wait", 2'd0, 1, 1, 1, 8'h08);
    step(1, 8'h18, 0, 0, 0);
    expect_out("R6 active osc on", 2'd0, 1, 1, 1, 8'h18);
    step(0, 8'h00, 0, 1, 0);
    expect_out("R8 wake in active", 2'd0, 1, 1, 1, 8'h08);

    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule